// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block steps a processor core through three power levels: full run, a grant level where only the core clock stops, and a doze level where only the PLL keeps running. An active-low stop request moves the core from run to grant. The request arrives asynchronously to the bus clock and passes through a flop synchronizer before the state machine uses it. A doze request is honoured only while the core sits in grant.

The block drives one clock-enable output per clock domain: core units, bus unit, interrupt-controller unit and PLL. It also drives two flags that allow or block snoop and interrupt servicing. When the core enters grant from run, the block emits a single-cycle request for the bus logic to issue a grant-acknowledge transaction. The gating cells, the bus sequencer and the PLL belong to the surrounding chip.

Top module: `pwr_state_ctrl`

## Requirements
- R1: While reset is low, and on release, the state code `pwr_state_o` is 0 (run). All clock enables and both service flags are 1, and `grant_ack_o` is 0. Other codes: 1 = grant, 2 = doze.
- R2: The active-low `stop_req_ni` is synchronized through `SYNC_STAGES` flops. With the default of 2 stages, a low level driven between two edges moves the state from 0 to 1 on the third rising edge. `grant_ack_o` is 1 for exactly the first cycle in state 1.
- R3: In grant, `core_clk_en_o` is 0. `bus_clk_en_o`, `apic_clk_en_o`, `pll_clk_en_o`, `snoop_en_o` and `irq_en_o` are 1.
- R4: With the stop request held low in grant, `doze_req_i` high moves the state to 2 on the next rising edge. `doze_req_i` high while in run leaves the state at 0.
- R5: In doze, only `pll_clk_en_o` is 1. The other three enables, `snoop_en_o` and `irq_en_o` are 0.
- R6: In doze, `doze_req_i` low moves the state to 1 on the next edge. The bus and interrupt enables turn back on, and `grant_ack_o` stays 0.
- R7: In grant, with `doze_req_i` low, a synchronized high on `stop_req_ni` returns the state to 0 with every enable and flag at 1.
- R8: In doze, a synchronized high on `stop_req_ni` moves the state to 1, never straight to 0. The state stays at 1 while `doze_req_i` remains high, and reaches 0 only after it falls.
- R9: `rst_ni` low forces state 0 and all enables on at once, with no clock edge, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stop_req_ni | input | 1 | Asynchronous active-low stop request |
| doze_req_i | input | 1 | Doze request, synchronous to clk_i |
| core_clk_en_o | output | 1 | Core-unit clock enable |
| bus_clk_en_o | output | 1 | Bus-unit clock enable |
| apic_clk_en_o | output | 1 | Interrupt-controller clock enable |
| pll_clk_en_o | output | 1 | PLL run enable |
| snoop_en_o | output | 1 | Snoops may be serviced |
| irq_en_o | output | 1 | Interrupts may be serviced |
| grant_ack_o | output | 1 | One-cycle grant-acknowledge transaction request |
| pwr_state_o | output | 2 | Current power state code |

## Verification
The bench builds the block with the default `SYNC_STAGES` of 2. This makes the stop-request latency exactly three rising edges, so the bench can sample the cycle before the change and the cycle of the change. It also places the one-cycle acknowledge in a known cycle. With this setting, short scenarios can cover the doze round trip, a stop release during doze while the doze request is still held, and an asynchronous reset taken mid-cycle from doze.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_GRANT = 2'd1,
    ST_DOZE  = 2'd2
  } pwr_state_e;

  localparam int unsigned STATE_W = 2;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {STAGES{RESET_VAL}};
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("pwr_sync: STAGES must be at least 2");
  end
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_syn_ni,
  input  logic       doze_req_i,
  output pwr_state_e state_o,
  output logic       ack_o
);
  pwr_state_e state_q, state_d;
  logic       ack_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:   if (!stop_syn_ni) state_d = ST_GRANT;
      ST_GRANT: begin
        if (!stop_syn_ni && doze_req_i)     state_d = ST_DOZE;
        else if (stop_syn_ni && !doze_req_i) state_d = ST_RUN;
      end
      ST_DOZE:  if (!doze_req_i || stop_syn_ni) state_d = ST_GRANT;
      default:  state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_q == ST_RUN) && (state_d == ST_GRANT);
    end
  end

  assign state_o = state_q;
  assign ack_o   = ack_q;

  // R2: ack is a lone pulse on entry from run
  p_ack_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  p_ack_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |-> (state_q == ST_GRANT && $past(state_q) == ST_RUN));
  // R4: doze entered only from grant
  p_doze_from_grant_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_DOZE) |-> $past(state_q) == ST_GRANT);
  // R8: doze never exits straight to run
  p_no_direct_wake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DOZE) |=> (state_q != ST_RUN));
endmodule

// File: rtl/pwr_decode.sv
module pwr_decode
  import pwr_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pwr_state_e state_i,
  output logic       core_en_o,
  output logic       bus_en_o,
  output logic       apic_en_o,
  output logic       pll_en_o,
  output logic       snoop_en_o,
  output logic       irq_en_o
);
  logic awake;

  assign awake      = (state_i != ST_DOZE);
  assign core_en_o  = (state_i == ST_RUN);
  assign bus_en_o   = awake;
  assign apic_en_o  = awake;
  assign pll_en_o   = 1'b1;
  assign snoop_en_o = awake;
  assign irq_en_o   = awake;

  // R3: core clock never runs without the bus clock
  p_core_needs_bus_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_en_o |-> bus_en_o);
  // R5: servicing flags follow the bus/interrupt clocks
  p_flags_track_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_en_o == apic_en_o) && (irq_en_o == apic_en_o));
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stop_req_ni,
  input  logic               doze_req_i,
  output logic               core_clk_en_o,
  output logic               bus_clk_en_o,
  output logic               apic_clk_en_o,
  output logic               pll_clk_en_o,
  output logic               snoop_en_o,
  output logic               irq_en_o,
  output logic               grant_ack_o,
  output logic [STATE_W-1:0] pwr_state_o
);
  logic       stop_syn_n;
  pwr_state_e state;

  pwr_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_stop_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (stop_req_ni),
    .q_o   (stop_syn_n)
  );

  pwr_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_syn_ni(stop_syn_n),
    .doze_req_i (doze_req_i),
    .state_o    (state),
    .ack_o      (grant_ack_o)
  );

  pwr_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .core_en_o (core_clk_en_o),
    .bus_en_o  (bus_clk_en_o),
    .apic_en_o (apic_clk_en_o),
    .pll_en_o  (pll_clk_en_o),
    .snoop_en_o(snoop_en_o),
    .irq_en_o  (irq_en_o)
  );

  assign pwr_state_o = state;

  // R7: leaving grant for run requires the synchronized stop release
  p_wake_needs_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_GRANT && !stop_syn_n) |=> (state != ST_RUN));
endmodule

// File: tb/pwr_state_ctrl_tb_top.sv
module pwr_state_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       stop_req_ni = 1'b1;
  logic       doze_req_i = 1'b0;
  logic       core_en, bus_en, apic_en, pll_en, snp_en, irq_en, ack;
  logic [1:0] st;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  pwr_state_ctrl #(.SYNC_STAGES(2)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_req_ni  (stop_req_ni),
    .doze_req_i   (doze_req_i),
    .core_clk_en_o(core_en),
    .bus_clk_en_o (bus_en),
    .apic_clk_en_o(apic_en),
    .pll_clk_en_o (pll_en),
    .snoop_en_o   (snp_en),
    .irq_en_o     (irq_en),
    .grant_ack_o  (ack),
    .pwr_state_o  (st)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // enables packed {core,bus,apic,pll,snoop,irq}
  function automatic logic [7:0] ens();
    return {2'b00, core_en, bus_en, apic_en, pll_en, snp_en, irq_en};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    check("R1 state", st, 8'd0);
    check("R1 enables", ens(), 8'h3f);
    check("R1 ack", ack, 8'd0);
    @(negedge clk_i) rst_ni = 1'b1;
    tick(1);
    check("R1 state after release", st, 8'd0);
  endtask

  task automatic t_doze_in_run;
    doze_req_i = 1'b1;
    tick(3);
    check("R4 doze ignored in run", st, 8'd0);
    check("R4 enables in run", ens(), 8'h3f);
    doze_req_i = 1'b0;
  endtask

  task automatic t_enter_grant;
    stop_req_ni = 1'b0;
    tick(2);
    check("R2 still run before sync", st, 8'd0);
    check("R2 no early ack", ack, 8'd0);
    tick(1);
    check("R2 grant state", st, 8'd1);
    check("R2 ack pulse", ack, 8'd1);
    check("R3 grant enables", ens(), 8'h1f);
    tick(1);
    check("R2 ack drops", ack, 8'd0);
    check("R3 grant held", st, 8'd1);
  endtask

  task automatic t_doze_cycle;
    doze_req_i = 1'b1;
    tick(1);
    check("R4 doze state", st, 8'd2);
    check("R5 doze enables", ens(), 8'h04);
    doze_req_i = 1'b0;
    tick(1);
    check("R6 back to grant", st, 8'd1);
    check("R6 no ack", ack, 8'd0);
    check("R6 enables", ens(), 8'h1f);
    doze_req_i = 1'b1;
    tick(1);
    check("R4 doze again", st, 8'd2);
  endtask

  task automatic t_stop_release_in_doze;
    stop_req_ni = 1'b1;
    tick(2);
    check("R8 doze before sync", st, 8'd2);
    tick(1);
    check("R8 doze to grant", st, 8'd1);
    check("R8 no ack", ack, 8'd0);
    tick(2);
    check("R8 held grant", st, 8'd1);
    doze_req_i = 1'b0;
    tick(1);
    check("R8 run after doze low", st, 8'd0);
    check("R7 all enables", ens(), 8'h3f);
  endtask

  task automatic t_grant_exit;
    stop_req_ni = 1'b0;
    tick(3);
    check("R2 grant re-entry", st, 8'd1);
    check("R2 ack re-entry", ack, 8'd1);
    stop_req_ni = 1'b1;
    tick(2);
    check("R7 grant before sync", st, 8'd1);
    tick(1);
    check("R7 run", st, 8'd0);
    check("R7 enables", ens(), 8'h3f);
  endtask

  task automatic t_async_reset;
    stop_req_ni = 1'b0;
    tick(3);
    doze_req_i = 1'b1;
    tick(1);
    check("R4 doze for reset", st, 8'd2);
    #2 rst_ni = 1'b0;
    #1;
    check("R9 async state", st, 8'd0);
    check("R9 async enables", ens(), 8'h3f);
    stop_req_ni = 1'b1;
    doze_req_i  = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    tick(4);
    check("R9 run after reset", st, 8'd0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #500us;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    #3;
    t_reset();
    t_doze_in_run();
    t_enter_grant();
    t_doze_cycle();
    t_stop_release_in_doze();
    t_grant_exit();
    t_async_reset();
    summary();
  end
endmodule